// File: doc/BRIEF.md
# Carry-Save Array Significand Multiplier

This block forms the unsigned product of two N-bit significands, as the mantissa path of a floating-point multiplier needs. It is built from gates only. Each partial-product bit is the AND of one bit of each operand. A first row of half adders and N-2 rows of full adders then reduce these bits. Every adder passes its carry diagonally down to the next row, not sideways along its own row. A single ripple-carry row at the bottom merges the remaining sum and carry vectors into the upper half of the product. The lower half of the product is taken from the rightmost sum of each row as the array is walked down.

A parameter selects a variant with one register row placed halfway down the array. In that variant the operands, the partial sums and carries at the cut, and the low product bits already formed are captured together. The product then appears one clock after its operands. Without the register the block is purely combinational. The register row uses a synchronous active-low reset.

Top module: `csa_array_mul`

## Requirements
- R1: For any operands, `product` equals the unsigned product of `op_a` and `op_b` over all 2N bits.
- R2: With the register row enabled (the default), `product` shows the result for the operands present at a rising clock edge from just after that edge on, and holds the previous result until that edge.
- R3: With the register row disabled, `product` equals the product of the operands currently applied, with no clock edge in between.
- R4: With the register row enabled, a rising edge with `rst_n` low clears the register row, and `product` reads 0 whatever the operands are.
- R5: If either operand is zero, `product` is zero.
- R6: When both operands are all ones, `product` is 2^(2N) - 2^(N+1) + 1. That is bit 0 set, bits 1 through N clear and bits N+1 through 2N-1 set.
- R7: When one operand is 1, `product` equals the other operand, zero-extended to 2N bits.
- R8: When the operands are 2^i and 2^j, only bit i+j of `product` is set. This holds both for bits taken from the row outputs and for bits taken from the merging row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register row |
| rst_n | input | 1 | Synchronous reset, active low, clears the register row |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| product | output | 2N | Unsigned product |

## Verification
The array is driven with zero operands, all-ones operands, the identity operand 1, and pairs of single-bit operands. Zero and identity operands show whether partial products are gated by the right operand bit. Single-bit pairs show whether each weight reaches its own output column, whether it leaves through a row's first column or through the merging chain. All-ones operands force every carry through the full diagonal path and the whole ripple merge. A long run of pseudo-random operands then covers mixed carry patterns. The registered and the combinational variants receive the same stimulus, and a directed sequence separates one clock of latency from zero, and shows that reset clears the register row.

// File: rtl/csa_mul_pkg.sv
// Package: shared types for the carry-save array multiplier.
// Assumes nothing beyond IEEE 1800-2017.
package csa_mul_pkg;
    // Selects whether the array has a register row at its midpoint.
    typedef enum logic {
        PIPE_OFF = 1'b0,
        PIPE_ON  = 1'b1
    } pipe_mode_e;

    // Result of one adder cell: carry and sum of a single column.
    typedef struct packed {
        logic carry;
        logic sum;
    } bit_sum_t;
endpackage

// File: rtl/csa_half_add.sv
// Module: csa_half_add
// Adds two bits of equal weight into a sum and a carry.
// Assumes both inputs carry the same column weight.
module csa_half_add
    import csa_mul_pkg::*;
(
    input  logic     x_in,
    input  logic     y_in,
    output bit_sum_t res
);
    // Purpose: form sum and carry of two bits.
    always_comb begin
        res.sum   = x_in ^ y_in;
        res.carry = x_in & y_in;
    end
endmodule

// File: rtl/csa_full_add.sv
// Module: csa_full_add
// Adds three bits of equal weight into a sum and a carry.
// Assumes all three inputs carry the same column weight.
module csa_full_add
    import csa_mul_pkg::*;
(
    input  logic     x_in,
    input  logic     y_in,
    input  logic     c_in,
    output bit_sum_t res
);
    // Purpose: form sum and majority carry of three bits.
    always_comb begin
        res.sum   = x_in ^ y_in ^ c_in;
        res.carry = (x_in & y_in) | (x_in & c_in) | (y_in & c_in);
    end
endmodule

// File: rtl/csa_row.sv
// Module: csa_row
// One full-adder row of the carry-save array. Column j adds the sum arriving
// from the row above, a fresh partial-product bit and the carry from the row
// above. Carries leave downward and are not chained along the row.
// Assumes the caller lines up the three vectors to equal column weights.
module csa_row
    import csa_mul_pkg::*;
#(
    parameter int unsigned W = 23
) (
    input  logic [W-1:0] top_in,
    input  logic [W-1:0] pp_in,
    input  logic [W-1:0] cin,
    output logic [W-1:0] sum_out,
    output logic [W-1:0] carry_out
);
    genvar j;
    generate
        for (j = 0; j < W; j++) begin : g_col
            bit_sum_t r;
            csa_full_add u_fa (
                .x_in (top_in[j]),
                .y_in (pp_in[j]),
                .c_in (cin[j]),
                .res  (r)
            );
            assign sum_out[j]   = r.sum;
            assign carry_out[j] = r.carry;
        end
    endgenerate
endmodule

// File: rtl/csa_merge.sv
// Module: csa_merge
// Vector-merging row: a ripple-carry adder with a half adder in column 0 and
// full adders above it. It turns the last row's sums and carries into binary.
// Assumes W >= 2. The result is W+1 bits wide, and its top bit is the final carry.
module csa_merge
    import csa_mul_pkg::*;
#(
    parameter int unsigned W = 23
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    output logic [W:0]   sum_out
);
    logic [W-1:0] cy;

    genvar j;
    generate
        for (j = 0; j < W; j++) begin : g_bit
            bit_sum_t r;
            if (j == 0) begin : g_ha
                csa_half_add u_ha (
                    .x_in (x_in[j]),
                    .y_in (y_in[j]),
                    .res  (r)
                );
            end else begin : g_fa
                csa_full_add u_fa (
                    .x_in (x_in[j]),
                    .y_in (y_in[j]),
                    .c_in (cy[j-1]),
                    .res  (r)
                );
            end
            assign sum_out[j] = r.sum;
            assign cy[j]      = r.carry;
        end
    endgenerate

    assign sum_out[W] = cy[W-1];
endmodule

// File: rtl/csa_array_mul.sv
// Module: csa_array_mul
// N x N unsigned carry-save array multiplier. Row 0 has N-1 half adders.
// Rows 1..N-2 have N-1 full adders each. Carries move diagonally into the
// next row. Product bit k+1 is the first-column sum of row k, and the upper
// N bits come from a ripple merging row. With PIPE_MODE = PIPE_ON a register
// row after row N/2-1 adds one clock of latency. The register row holds the
// operands, the sums and carries at the cut, and the low bits already formed.
// Assumes N >= 4. The reset is synchronous and active low.
module csa_array_mul
    import csa_mul_pkg::*;
#(
    parameter int unsigned N         = 24,
    parameter pipe_mode_e  PIPE_MODE = PIPE_ON
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] product
);
    localparam int unsigned W    = N - 1;     // adders per row
    localparam int unsigned ROWS = N - 1;     // row 0 plus N-2 full-adder rows
    localparam int unsigned CUT  = N / 2 - 1; // row whose outputs may be registered

    logic [W-1:0]   rs [ROWS];   // row sums
    logic [W-1:0]   rc [ROWS];   // row carries
    logic [W-2:0]   fs [ROWS];   // sums forwarded to the next row (bit 0 leaves as product)
    logic [W-1:0]   fc [ROWS];   // carries forwarded to the next row
    logic [N-1:0]   a_d;         // multiplicand seen below the cut
    logic [N-1:CUT+1] b_d;       // multiplier bits seen below the cut
    logic [CUT+1:0] low_live;    // product bits formed above the cut
    logic [N:0]     merged;      // merging row result

    // Row 0: half adders on the first two partial-product rows.
    genvar j, k;
    generate
        for (j = 0; j < W; j++) begin : g_row0
            bit_sum_t r;
            csa_half_add u_ha (
                .x_in (op_a[j+1] & op_b[0]),
                .y_in (op_a[j]   & op_b[1]),
                .res  (r)
            );
            assign rs[0][j] = r.sum;
            assign rc[0][j] = r.carry;
        end

        // Rows 1..N-2: full-adder rows fed diagonally by the row above.
        for (k = 1; k < ROWS; k++) begin : g_rows
            logic [W-1:0] pp_v;
            logic         msb_v;
            if (k > CUT) begin : g_below
                assign pp_v  = a_d[W-1:0] & {W{b_d[k+1]}};
                assign msb_v = a_d[N-1] & b_d[k];
            end else begin : g_above
                assign pp_v  = op_a[W-1:0] & {W{op_b[k+1]}};
                assign msb_v = op_a[N-1] & op_b[k];
            end
            csa_row #(.W(W)) u_row (
                .top_in    ({msb_v, fs[k-1]}),
                .pp_in     (pp_v),
                .cin       (fc[k-1]),
                .sum_out   (rs[k]),
                .carry_out (rc[k])
            );
        end

        // Forwarding from each row, except the registered cut.
        for (k = 0; k < ROWS; k++) begin : g_fwd
            if (!(PIPE_MODE == PIPE_ON && k == CUT)) begin : g_wire
                assign fs[k] = rs[k][W-1:1];
                assign fc[k] = rc[k];
            end
        end

        // Low product bits produced at or above the cut.
        assign low_live[0] = op_a[0] & op_b[0];
        for (k = 0; k <= CUT; k++) begin : g_low
            assign low_live[k+1] = rs[k][0];
        end

        // Optional register row at the cut.
        if (PIPE_MODE == PIPE_ON) begin : g_pipe
            logic [W-2:0]     fs_q;
            logic [W-1:0]     fc_q;
            logic [CUT+1:0]   low_q;
            logic [N-1:0]     a_q;
            logic [N-1:CUT+1] b_q;

            // Purpose: capture the array state at the cut, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fs_q  <= '0;
                    fc_q  <= '0;
                    low_q <= '0;
                    a_q   <= '0;
                    b_q   <= '0;
                end else begin
                    fs_q  <= rs[CUT][W-1:1];
                    fc_q  <= rc[CUT];
                    low_q <= low_live;
                    a_q   <= op_a;
                    b_q   <= op_b[N-1:CUT+1];
                end
            end

            assign fs[CUT]           = fs_q;
            assign fc[CUT]           = fc_q;
            assign a_d               = a_q;
            assign b_d               = b_q;
            assign product[CUT+1:0]  = low_q;
        end else begin : g_comb
            assign a_d               = op_a;
            assign b_d               = op_b[N-1:CUT+1];
            assign product[CUT+1:0]  = low_live;
        end

        // Product bits taken from the first column of rows below the cut.
        for (k = CUT + 1; k < ROWS; k++) begin : g_mid
            assign product[k+1] = rs[k][0];
        end
    endgenerate

    // Vector-merging row: last row's sums against its carries.
    csa_merge #(.W(W)) u_merge (
        .x_in    ({a_d[N-1] & b_d[N-1], fs[ROWS-1]}),
        .y_in    (fc[ROWS-1]),
        .sum_out (merged)
    );

    assign product[2*N-1:N] = merged[W:0];
endmodule

// File: rtl/csa_array_mul_chk.sv
// Module: csa_array_mul_chk
// Property checker for csa_array_mul. It compares the port product against a
// reference product with the latency of the chosen variant. It also checks the
// zero, all-ones and reset behaviour. It is attached by the bind at the end of
// this file. It assumes that inputs change away from the rising clock edge.
module csa_array_mul_chk
    import csa_mul_pkg::*;
#(
    parameter int unsigned N         = 24,
    parameter pipe_mode_e  PIPE_MODE = PIPE_ON
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [2*N-1:0] product
);
    localparam int W2 = 2 * N;

    generate
        if (PIPE_MODE == PIPE_ON) begin : g_seq
            logic was_in_rst;

            // R1, R2: result of the previous edge's operands, one clock later.
            assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> product == (W2'($past(op_a)) * W2'($past(op_b))));

            // R5: a zero operand yields zero on the next clock.
            assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (op_a == '0 || op_b == '0) |=> product == '0);

            // R6: all-ones operands give the fixed bit pattern.
            assert_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (&op_a && &op_b) |=> (product[0] && product[N:1] == '0 && &product[W2-1:N+1]));

            // Purpose: R4, a reset edge leaves product at zero until the next edge.
            always_ff @(posedge clk) begin
                was_in_rst <= !rst_n;
                if (was_in_rst) begin
                    assert_reset_clear_R4: assert (product == '0)
                        else $error("product not cleared after reset");
                end
            end
        end else begin : g_cmb
            // R3: combinational variant matches current operands.
            assert_comb_R3: assert property (@(posedge clk) disable iff (!rst_n)
                product == (W2'(op_a) * W2'(op_b)));
        end
    endgenerate
endmodule

bind csa_array_mul csa_array_mul_chk #(
    .N         (N),
    .PIPE_MODE (PIPE_MODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
);

// File: tb/csa_array_mul_bench.sv
// Bench: csa_array_mul_bench
// Drives a registered and a combinational instance with the same operands.
// It walks a table of operand and expected-product vectors, then runs directed
// latency and reset tests and a pseudo-random sweep.
module csa_array_mul_bench;
    localparam int N  = 24;
    localparam int W2 = 2 * N;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  a = '0;
    logic [N-1:0]  b = '0;
    logic [W2-1:0] p_reg;
    logic [W2-1:0] p_cmb;
    int            n_chk = 0;
    int            n_err = 0;
    bit            done = 1'b0;

    // Operand A, operand B, expected product.
    localparam logic [95:0] VEC [NV] = '{
        {24'h000000, 24'h000000, 48'h000000000000},   // R5
        {24'h000000, 24'hFFFFFF, 48'h000000000000},   // R5
        {24'hABCDEF, 24'h000000, 48'h000000000000},   // R5
        {24'hFFFFFF, 24'hFFFFFF, 48'hFFFFFE000001},   // R6
        {24'h000001, 24'h123456, 48'h000000123456},   // R7
        {24'h9ABCDE, 24'h000001, 48'h0000009ABCDE},   // R7
        {24'h800000, 24'h800000, 48'h400000000000},   // R8
        {24'h000001, 24'h800000, 48'h000000800000},   // R8
        {24'h000010, 24'h000100, 48'h000000001000},   // R8
        {24'h001000, 24'h001000, 48'h000001000000},   // R8
        {24'h000003, 24'h000005, 48'h00000000000F},   // R1
        {24'hFFFFFF, 24'h000002, 48'h000001FFFFFE}    // R1
    };
    localparam int TAG [NV] = '{5, 5, 5, 6, 7, 7, 8, 8, 8, 8, 1, 1};

    always #10 clk = ~clk;

    csa_array_mul #(.N(N)) u_csa_array_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (a),
        .op_b    (b),
        .product (p_reg)
    );

    csa_array_mul #(.N(N), .PIPE_MODE(csa_mul_pkg::PIPE_OFF)) u_csa_array_mul_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (a),
        .op_b    (b),
        .product (p_cmb)
    );

    task automatic chk(input string req, input logic [W2-1:0] got, input logic [W2-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        logic [W2-1:0] prev;
        logic [31:0]   lfsr;
        // R4: reset with nonzero operands leaves the registered product at zero.
        a = 24'hABCDEF;
        b = 24'h123456;
        repeat (3) @(negedge clk);
        chk("R4 reset state", p_reg, '0);
        rst_n = 1'b1;

        // Table walk: registered result one edge later, comb result immediately.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a = VEC[i][95:72];
            b = VEC[i][71:48];
            @(negedge clk);
            chk($sformatf("R%0d registered vec %0d", TAG[i], i), p_reg, VEC[i][47:0]);
            chk($sformatf("R%0d comb vec %0d", TAG[i], i), p_cmb, VEC[i][47:0]);
        end

        // R2 and R3: one clock of latency against zero latency.
        @(negedge clk);
        prev = p_reg;
        a = 24'h000007;
        b = 24'h000009;
        #1;
        chk("R2 holds old result before edge", p_reg, prev);
        chk("R3 comb follows operands", p_cmb, 48'd63);
        @(posedge clk);
        #1;
        chk("R2 new result after edge", p_reg, 48'd63);

        // R1: pseudo-random sweep against the behavioural product.
        lfsr = 32'h1D872B41;
        for (int i = 0; i < 300; i++) begin
            logic [N-1:0] ra, rb;
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr[23:0];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = lfsr[31:8];
            a = ra;
            b = rb;
            @(negedge clk);
            chk("R1 random registered", p_reg, {24'b0, ra} * {24'b0, rb});
            chk("R1 random comb", p_cmb, {24'b0, ra} * {24'b0, rb});
        end

        // R4: reset in mid-run clears the register row despite live operands.
        @(negedge clk);
        a = 24'hFFFFFF;
        b = 24'hFFFFFF;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R4 cleared in reset", p_reg, '0);
        @(negedge clk);
        chk("R4 held at zero in reset", p_reg, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 after reset release", p_reg, 48'hFFFFFE000001);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule